// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames as a byte stream and stores each one into memory through a ring of 16-byte descriptors that software prepares. For every frame it reads the status word of the current descriptor. If software still owns that descriptor, the frame is discarded and a missed-frame counter advances. Otherwise the block reads the buffer pointer and writes the frame bytes into that buffer as they arrive. When the frame ends, it decides whether to keep the frame. That decision uses the destination address, the frame length and the CRC flag, checked against six accept-mode bits. A kept frame has its status word written back, with ownership cleared and with the length and error causes filled in. The block then moves on to the next descriptor.

The frame input is a valid/ready stream. The source must hold `s_data`, `s_last` and `s_crc_err` steady while `s_valid` is high and `s_ready` is low. The block drops `s_ready`:
- while it fetches a descriptor at the start of a frame;
- while it writes back the status word;
- while a byte headed for the buffer waits on a stalled memory.

Bytes that fall past the end of the buffer, and every byte of a dropped frame, are accepted at once. The memory port is a single master. A request is taken in a cycle where `mem_valid` and `mem_ready` are both high. Read data returns later, flagged by `mem_rvalid`.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: Descriptor `i` lives at `{cfg_ring_page, 8'h00} + 16*i`. The status word is at offset 0 and the buffer pointer at offset 8. After a descriptor with bit 30 (end of ring) set is handed back, the index returns to 0; after any other is handed back, it goes up by one. The index does not move in any other case.
- R2: The write-back status word holds the following fields, and every other bit is zero. It is written with byte enables 4'hF.
  - bit 31 (ownership): cleared.
  - bit 30: copied from the descriptor.
  - bits 12:0: the stored length, including the 4 CRC bytes.
  - bit 22: too long.
  - bit 21: error summary.
  - bit 20: runt.
  - bit 19: CRC error.
- R3: Byte k of a frame is written to byte address `buf+k`. It is written as a single-lane word write, with `mem_be = 1 << addr[1:0]` and the byte copied onto all four lanes. Memory words are little-endian.
- R4: The buffer size is taken from descriptor status bits 12:0. Bytes at offset `size` or beyond are not written. Such a frame reports length `size` and has bits 22 and 21 set.
- R5: If the fetched status has bit 31 clear, the whole frame is consumed with no memory write and `rx_missed` goes up by one.
- R6: The destination address is the first six bytes. `cfg_station_mac[47:40]` is compared with the first byte on the wire. Mode bits decide which frames pass:
  - 0x01 passes every frame;
  - 0x02 passes a unicast frame (first byte bit 0 clear) equal to the station address;
  - 0x04 passes a group frame that is not broadcast;
  - 0x08 passes broadcast (all 0xFF).
  A frame of fewer than 6 bytes passes only with 0x01.
- R7: A frame shorter than 64 bytes is a runt and sets bits 20 and 21. It is dropped unless mode bit 0x10 is set.
- R8: `s_crc_err`, sampled with the last byte, sets bits 19 and 21. A frame with a CRC error or a too-long condition is dropped unless mode bit 0x20 is set.
- R9: A dropped frame leaves the descriptor status word in memory unchanged. It does not advance the index and raises no interrupt bit.
- R10: `irq_status` bits are sticky and are cleared by writing one to the matching `irq_clr` bit; a set in the same cycle wins over the clear. The bits are:
  - bit 0 (0x01): a frame handed back with no error summary;
  - bit 1 (0x02): a frame handed back with the summary set;
  - bit 4 (0x10): a frame missed because the descriptor was not owned.
  After reset, `irq_status` and `rx_missed` are zero.
- R11: `s_ready` is high only while a frame is being received or dropped. In particular it is low in the cycle the first byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_page | input | 24 | Ring base address bits 31:8 |
| cfg_rx_mode | input | 6 | Accept-mode bits |
| cfg_station_mac | input | 48 | Station address, first wire byte in bits 47:40 |
| irq_clr | input | 8 | Write-one-to-clear for irq_status |
| irq_status | output | 8 | Sticky event bits |
| rx_missed | output | 32 | Frames missed for lack of an owned descriptor |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_crc_err | input | 1 | CRC failure, valid with s_last |

## Verification
The assertions check, on every cycle, properties that hold regardless of frame content:
- `s_ready` is only high in the receive and drop phases;
- buffer stores use exactly one byte lane;
- a status write-back always clears ownership and targets the current descriptor;
- the descriptor index moves only on a write-back;
- `rx_missed` steps by at most one, and only together with the overflow bit;
- interrupt bits stay set until they are cleared.

Whether a frame should be kept, and the exact status word, length, truncation point and stored bytes, depend on the mode, address class, length and CRC flag together. Only the bench's sweep over all 64 modes against an arithmetic model can show those.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W   = 13;
  localparam int ST_OWN  = 31;
  localparam int ST_EOR  = 30;
  localparam int ST_WDOG = 22;
  localparam int ST_ES   = 21;
  localparam int ST_RUNT = 20;
  localparam int ST_CRC  = 19;

  localparam int MD_ALL  = 0;
  localparam int MD_MINE = 1;
  localparam int MD_GRP  = 2;
  localparam int MD_BC   = 3;
  localparam int MD_RUNT = 4;
  localparam int MD_ERR  = 5;

  localparam int IRQ_W   = 8;
  localparam int IRQ_OK  = 0;
  localparam int IRQ_ERR = 1;
  localparam int IRQ_OVF = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_DWT, S_BRD, S_BWT, S_RECV, S_DROP, S_DONE
  } rx_state_e;
endpackage

// File: rtl/rxr_len_meter.sv
module rxr_len_meter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                        count <= '0;
    else if (clear)                    count <= '0;
    else if (step && count != CNT_MAX) count <= count + 1'b1;
  end

  // R2: the length only grows while a frame is in flight
  a_r2_len_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count >= $past(count)));
endmodule

// File: rtl/rxr_da_filter.sv
module rxr_da_filter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [7:0]       data,
  input  logic [CNT_W-1:0] pos,
  input  logic [47:0]      station,
  input  logic [3:0]       mode,
  output logic             pass
);
  import rxr_pkg::*;
  localparam int DA_BYTES = 6;

  logic mine_q, bc_q, grp_q, full_q;
  logic [7:0] st_byte;

  always_comb begin
    st_byte = '0;
    for (int i = 0; i < DA_BYTES; i++)
      if (pos == CNT_W'(i)) st_byte = station[8*(DA_BYTES-1-i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mine_q <= 1'b1;
      bc_q   <= 1'b1;
      grp_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (step && pos < CNT_W'(DA_BYTES)) begin
      mine_q <= mine_q & (data == st_byte);
      bc_q   <= bc_q & (data == 8'hFF);
      if (pos == '0) grp_q <= data[0];
      if (pos == CNT_W'(DA_BYTES-1)) full_q <= 1'b1;
    end
  end

  assign pass = mode[MD_ALL] |
                (full_q & ((!grp_q & mine_q & mode[MD_MINE]) |
                           ( grp_q & bc_q   & mode[MD_BC])   |
                           ( grp_q & !bc_q  & mode[MD_GRP])));

  // R6: a complete all-ones address is always classed as a group address
  a_r6_bcast_is_group: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && bc_q) |-> grp_q);
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 8,
  parameter int MIN_FRAME = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-9:0]             cfg_ring_page,
  input  logic [5:0]                    cfg_rx_mode,
  input  logic [47:0]                   cfg_station_mac,
  input  logic [rxr_pkg::IRQ_W-1:0]     irq_clr,
  output logic [rxr_pkg::IRQ_W-1:0]     irq_status,
  output logic [31:0]                   rx_missed,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [3:0]                    mem_be,
  output logic [31:0]                   mem_wdata,
  input  logic                          mem_rvalid,
  input  logic [31:0]                   mem_rdata,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [7:0]                    s_data,
  input  logic                          s_last,
  input  logic                          s_crc_err
);
  import rxr_pkg::*;
  localparam int CNT_W   = LEN_W + 1;
  localparam int PTR_OFS = 8;

  rx_state_e          state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               eor_q, crc_q;
  logic [LEN_W-1:0]   bufsz_q;
  logic [ADDR_W-1:0]  buf_q;
  logic [CNT_W-1:0]   cnt;
  logic               pass;

  logic [ADDR_W-1:0]  desc_addr, byte_addr;
  logic               hs, store_ok, too_long, runt, err_cls, keep, summary, wb_fire;
  logic [31:0]        wb_word;
  logic [IRQ_W-1:0]   irq_set;

  assign desc_addr = {cfg_ring_page, 8'h00} + {{(ADDR_W-IDX_W-4){1'b0}}, idx_q, 4'b0000};
  assign byte_addr = buf_q + ADDR_W'(cnt);
  assign hs        = s_valid && s_ready;
  assign store_ok  = cnt < CNT_W'(bufsz_q);
  assign too_long  = cnt > CNT_W'(bufsz_q);
  assign runt      = cnt < CNT_W'(MIN_FRAME);
  assign err_cls   = crc_q | too_long;
  assign summary   = err_cls | runt;
  assign keep      = pass && (!runt || cfg_rx_mode[MD_RUNT]) && (!err_cls || cfg_rx_mode[MD_ERR]);
  assign wb_fire   = (state_q == S_DONE) && keep && mem_ready;

  rxr_len_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .clear(state_q == S_IDLE),
    .step(hs && state_q == S_RECV), .count(cnt));

  rxr_da_filter #(.CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .clear(state_q == S_IDLE),
    .step(hs && state_q == S_RECV), .data(s_data), .pos(cnt),
    .station(cfg_station_mac), .mode(cfg_rx_mode[3:0]), .pass(pass));

  always_comb begin
    wb_word               = '0;
    wb_word[ST_EOR]       = eor_q;
    wb_word[ST_WDOG]      = too_long;
    wb_word[ST_ES]        = summary;
    wb_word[ST_RUNT]      = runt;
    wb_word[ST_CRC]       = crc_q;
    wb_word[LEN_W-1:0]    = too_long ? bufsz_q : cnt[LEN_W-1:0];
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'hF;
    mem_wdata = wb_word;
    s_ready   = 1'b0;
    unique case (state_q)
      S_DRD: mem_valid = 1'b1;
      S_BRD: begin
        mem_valid = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(PTR_OFS);
      end
      S_RECV: begin
        mem_valid = s_valid && store_ok;
        mem_we    = 1'b1;
        mem_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{s_data}};
        s_ready   = store_ok ? mem_ready : 1'b1;
      end
      S_DROP: s_ready = 1'b1;
      S_DONE: begin
        mem_valid = keep;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    irq_set = '0;
    if (state_q == S_DWT && mem_rvalid && !mem_rdata[ST_OWN]) irq_set[IRQ_OVF] = 1'b1;
    if (wb_fire) begin
      if (summary) irq_set[IRQ_ERR] = 1'b1;
      else         irq_set[IRQ_OK]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      eor_q      <= 1'b0;
      crc_q      <= 1'b0;
      bufsz_q    <= '0;
      buf_q      <= '0;
      irq_status <= '0;
      rx_missed  <= '0;
    end else begin
      irq_status <= (irq_status & ~irq_clr) | irq_set;
      unique case (state_q)
        S_IDLE: if (s_valid) state_q <= S_DRD;
        S_DRD:  if (mem_ready) state_q <= S_DWT;
        S_DWT: if (mem_rvalid) begin
          eor_q   <= mem_rdata[ST_EOR];
          bufsz_q <= mem_rdata[LEN_W-1:0];
          if (mem_rdata[ST_OWN]) state_q <= S_BRD;
          else begin
            state_q   <= S_DROP;
            rx_missed <= rx_missed + 32'd1;
          end
        end
        S_BRD:  if (mem_ready) state_q <= S_BWT;
        S_BWT: if (mem_rvalid) begin
          buf_q   <= mem_rdata[ADDR_W-1:0];
          state_q <= S_RECV;
        end
        S_RECV: if (hs && s_last) begin
          crc_q   <= s_crc_err;
          state_q <= S_DONE;
        end
        S_DROP: if (hs && s_last) state_q <= S_IDLE;
        S_DONE: begin
          if (!keep) state_q <= S_IDLE;
          else if (mem_ready) begin
            state_q <= S_IDLE;
            idx_q   <= eor_q ? '0 : idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: the stream is only accepted while receiving or dropping
  a_r11_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (state_q == S_RECV || state_q == S_DROP));
  // R3: each buffer store touches exactly one byte lane
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECV && mem_valid) |-> (mem_we && $countones(mem_be) == 1));
  // R2: write-back releases ownership of the current descriptor
  a_r2_release_own: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && mem_valid) |-> (!mem_wdata[ST_OWN] && mem_be == 4'hF && mem_addr == desc_addr));
  // R1: the ring index moves only on an accepted write-back
  a_r1_idx_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == S_DONE && mem_valid && mem_ready) |=> $stable(idx_q));
  // R5: missed count steps by one at most, together with the overflow flag
  a_r5_missed_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_missed == $past(rx_missed) ||
              (rx_missed == $past(rx_missed) + 32'd1 && irq_status[IRQ_OVF])));
  // R10: event bits stay set until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_status) & ~$past(irq_clr) & ~irq_status) == '0));
endmodule

// File: tb/sim_rx_desc_ring_writer.sv
module sim_rx_desc_ring_writer;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_rx_mode = '0;
  logic [7:0]  irq_clr = '0;
  logic [7:0]  irq_status;
  logic [31:0] rx_missed;
  logic        mem_valid, mem_we, mem_rvalid = 1'b0;
  logic        mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        s_valid = 1'b0, s_ready, s_last = 1'b0, s_crc_err = 1'b0;
  logic [7:0]  s_data = '0;

  logic [7:0]  mem [0:4095];
  logic        bd_we = 1'b0;
  logic [11:0] bd_addr = '0;
  logic [31:0] bd_word = '0;
  logic [15:0] lfsr = 16'hACE1;

  int n_tests = 0, n_fail = 0, exp_idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_desc_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ring_page(24'h000001), .cfg_rx_mode(cfg_rx_mode),
    .cfg_station_mac(MAC), .irq_clr(irq_clr), .irq_status(irq_status), .rx_missed(rx_missed),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_crc_err(s_crc_err));

  assign mem_ready = lfsr[0] | lfsr[3];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (bd_we)
      for (int b = 0; b < 4; b++) mem[bd_addr + 12'(b)] <= bd_word[8*b +: 8];
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_addr[11:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata  <= {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                       mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};
        mem_rvalid <= 1'b1;
      end
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bd_wr(input int a, input logic [31:0] w);
    @(negedge clk); bd_we = 1'b1; bd_addr = 12'(a); bd_word = w;
    @(negedge clk); bd_we = 1'b0;
  endtask

  function automatic logic [31:0] desc_stat(input int i, input bit own, input int sz);
    return {own, (i == 3), 17'b0, 13'(sz)};
  endfunction

  function automatic logic [7:0] fbyte(input int k, input int cls, input int seed);
    if (k < 6) begin
      case (cls)
        0: return MAC[8*(5-k) +: 8];
        1: return MAC[8*(5-k) +: 8] ^ ((k == 5) ? 8'h01 : 8'h00);
        2: return 8'hFF;
        default: return (k == 0) ? 8'h01 : 8'(8'h5E + k);
      endcase
    end
    return 8'(k*13 + seed);
  endfunction

  task automatic send_frame(input int n, input int cls, input bit crc, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fbyte(k, cls, seed);
      s_last = (k == n-1); s_crc_err = crc && (k == n-1);
      forever begin
        bit got;
        #1 got = s_ready;
        if (k == 0 && !got) ; 
        @(posedge clk);
        if (got) break;
        @(negedge clk);
      end
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0; s_crc_err = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 8'hFF;
    @(negedge clk); irq_clr = 8'h00;
  endtask

  task automatic run_case(input int mode, input int cls, input int n, input bit crc, input int bsz);
    bit addr_ok, runt, lng, errc, keep;
    int len, buf_base, seed, mism, d;
    logic [31:0] st, armed;
    string tag;
    seed = mode*7 + cls;
    d = 32'h100 + 16*exp_idx;
    buf_base = 32'h400 + 32'h100*exp_idx;
    armed = desc_stat(exp_idx, 1'b1, bsz);
    bd_wr(d, armed);
    @(negedge clk); cfg_rx_mode = 6'(mode);
    #1 chk(s_ready == 1'b0, "R11 idle not ready", 32'(s_ready), 0);
    send_frame(n, cls, crc, seed);
    repeat (24) @(negedge clk);
    addr_ok = mode[0] || (n >= 6 && ((cls == 0 && mode[1]) || (cls == 2 && mode[3]) || (cls == 3 && mode[2])));
    runt = n < 64; lng = n > bsz; errc = crc || lng;
    keep = addr_ok && (!runt || mode[4]) && (!errc || mode[5]);
    len  = lng ? bsz : n;
    st = {1'b0, (exp_idx == 3), 7'b0, lng, errc || runt, runt, crc, 6'b0, 13'(len)};
    if (keep) begin
      chk(rd32(d) == st, "R1/R2 status at expected slot", rd32(d), st);
      mism = 0;
      for (int k = 0; k < len; k++) if (mem[buf_base + k] != fbyte(k, cls, seed)) mism++;
      chk(mism == 0, "R3 buffer bytes", 32'(mism), 0);
      chk(irq_status == ((errc || runt) ? 8'h02 : 8'h01), "R10 irq", 32'(irq_status),
          (errc || runt) ? 32'h2 : 32'h1);
      exp_idx = (exp_idx == 3) ? 0 : exp_idx + 1;
    end else begin
      chk(rd32(d) == armed, "R9 descriptor untouched", rd32(d), armed);
      tag = !addr_ok ? "R6 filtered" : (runt && !mode[4]) ? "R7 runt dropped" : "R8 error dropped";
      chk(irq_status == 8'h00, tag, 32'(irq_status), 0);
    end
    clear_irq();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m0, armed;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(irq_status == 0, "R10 reset irq", 32'(irq_status), 0);
    chk(rx_missed == 0, "R5 reset missed", rx_missed, 0);
    chk(s_ready == 0, "R11 reset ready", 32'(s_ready), 0);
    chk(mem_valid == 0, "R1 reset no request", 32'(mem_valid), 0);
    for (int i = 0; i < 4; i++) begin
      bd_wr(32'h108 + 16*i, 32'h400 + 32'h100*i);
      bd_wr(32'h100 + 16*i, desc_stat(i, 1'b1, 200));
    end
    for (int m = 0; m < 64; m++)
      for (int c = 0; c < 4; c++)
        for (int kd = 0; kd < 3; kd++)
          run_case(m, c, (kd == 1) ? 40 : 70, kd == 2, 200);
    // R4: truncation kept with accept-error, canary beyond the buffer end
    bd_wr(32'h400 + 32'h100*exp_idx + 48, 32'hEEEEEEEE);
    begin
      int bb;
      bb = 32'h400 + 32'h100*exp_idx;
      run_case(6'h22, 0, 90, 1'b0, 50);
      chk(mem[bb+50] == 8'hEE && mem[bb+51] == 8'hEE, "R4 no store past buffer",
          {mem[bb+51], mem[bb+50]}, 32'hEEEE);
    end
    run_case(6'h02, 0, 90, 1'b0, 50);   // R4/R8: too long without accept-error
    run_case(6'h11, 1, 5, 1'b0, 200);   // R6/R7: 5-byte runt with accept-all
    run_case(6'h12, 0, 5, 1'b0, 200);   // R6: incomplete address not matched
    // R5: descriptor not owned
    m0 = rx_missed;
    armed = desc_stat(exp_idx, 1'b0, 200);
    bd_wr(32'h100 + 16*exp_idx, armed);
    send_frame(70, 0, 1'b0, 3);
    repeat (24) @(negedge clk);
    chk(rx_missed == m0 + 1, "R5 missed count", rx_missed, m0 + 1);
    chk(irq_status == 8'h10, "R5 overflow irq", 32'(irq_status), 32'h10);
    chk(rd32(32'h100 + 16*exp_idx) == armed, "R5 descriptor untouched", rd32(32'h100 + 16*exp_idx), armed);
    clear_irq();
    #1 chk(irq_status == 0, "R10 write-one clear", 32'(irq_status), 0);
    run_case(6'h02, 0, 70, 1'b0, 200);  // R1: index did not move on the miss
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule